// File: doc/BRIEF.md
# Flash command interface decoder

This block is the command-interpretation front end of a parallel NOR flash device. Bus write cycles carry an 8-bit command code in the low byte of the data word. The block decodes that code into a read mode and launches program and erase operations towards a write-state-machine stub. It also keeps a status register whose error flags are sticky. On each read cycle it returns one of four sources: array data, the status byte, identifier words or query-table bytes. The result is registered and is presented one clock after the read request.

Program is a two-write sequence: a setup code followed by a data write. Block erase is also two writes: a setup code followed by a confirm code. If an erase sequence is not confirmed, it is abandoned and a command-sequence error is flagged in two status bits. Any code the decoder does not recognise moves the device into status-read mode. Software that expected array data therefore sees status, so a stray write cannot leave the device silently returning array contents. The memory array itself and the program/erase algorithms sit outside this block. The array is seen through a data input, and the algorithms are seen through a busy input and an error-set input.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset the read mode is array, all status error bits are 0, and `rd_valid`, `start_prog` and `start_erase` are 0.
- R2: Code 0xFF selects array mode. A read then returns `arr_data` as it stood in the request cycle.
- R3: Code 0x70 selects status mode. A read returns the status byte on bits 7:0 with bits 15:8 zero. Status bit 7 is 1 when `wsm_busy` is 0 and 0 while it is 1. Bits 6, 2 and 0 always read 0.
- R4: Code 0x90 selects identifier mode. The word is picked by the low 4 address bits: offset 0 returns MFR_ID (default 0x0089), 1 returns DEV_ID (default 0x8817), 5 returns CFG_WORD (default 0xBFCF), and every other offset returns 0.
- R5: Code 0x98 selects query mode. The byte is picked by the low 6 address bits on bits 7:0, with bits 15:8 zero: 0x10 gives 0x51, 0x11 gives 0x52, 0x12 gives 0x59, 0x13 gives 0x01, 0x27 gives 0x17, and every other offset gives 0.
- R6: A 1 on `wsm_err_set` bits 5, 4, 3 or 1 sets that status bit, and the bit stays set; the other bits of that input are ignored. Only code 0x50 clears the error bits. A set in the same cycle as 0x50 wins. Code 0x50 leaves the read mode unchanged.
- R7: Code 0x40 selects status mode. The next write, whatever its value, is taken as program data: one cycle later `start_prog` pulses for one clock, with `op_addr`/`op_data` holding that write's address and data, and the mode stays status.
- R8: Code 0x20 followed by 0xD0 pulses `start_erase` one cycle after the confirm write, with `op_addr` holding the confirm address; the mode is status.
- R9: After 0x20, any second write other than 0xD0 sets status bits 5 and 4, starts nothing, leaves status mode, and ends the sequence so the next write is decoded as a new command.
- R10: Any code outside 0xFF, 0x70, 0x90, 0x98, 0x50, 0x40, 0x20 written as a first cycle (for example 0x00 or a lone 0xD0) selects status mode. Command decoding looks only at data bits 7:0.
- R11: `rd_valid` is high exactly one cycle after each `rd_en`. The returned data follows the mode in force during the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; bits 7:0 hold the command code |
| rd_en | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array word for `rd_addr` from the array stub |
| wsm_busy | input | 1 | Write-state-machine stub is running an operation |
| wsm_err_set | input | 8 | Per-bit status error set pulses from the stub |
| rd_data | output | DATA_W | Registered read result |
| rd_valid | output | 1 | `rd_data` holds a result this cycle |
| start_prog | output | 1 | One-cycle program launch pulse |
| start_erase | output | 1 | One-cycle erase launch pulse |
| op_addr | output | ADDR_W | Address of the launched operation |
| op_data | output | DATA_W | Data of the launched program |

## Verification
Reads are tried in all four modes. Each mode uses address patterns that pick the distinct words of that mode, so a wrong source or a wrong offset decode shows up as a different value. The two-cycle sequences are run in three forms: properly confirmed, broken by a non-confirm code, and with program data that looks like a command. This separates sequence tracking from fresh decoding. Illegal codes are issued from array mode, so a decoder that keeps the old mode is exposed by returning array data. Error sets are driven with all eight bits at once and together with the clear command, which checks the bit mask and the priority of set over clear.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [1:0] {MODE_ARRAY, MODE_STATUS, MODE_IDENT, MODE_QUERY} rmode_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam int SR_READY = 7;
  localparam logic [7:0] SR_ERR_MASK = 8'b0011_1010;
  localparam logic [7:0] SR_SEQ_ERR  = 8'b0011_0000;

  function automatic logic [7:0] query_byte(input logic [5:0] off);
    case (off)
      6'h10:   query_byte = 8'h51;
      6'h11:   query_byte = 8'h52;
      6'h12:   query_byte = 8'h59;
      6'h13:   query_byte = 8'h01;
      6'h27:   query_byte = 8'h17;
      default: query_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output rmode_e            mode_q,
  output seq_e              seq_q,
  output logic              clr_req,
  output logic              seq_err,
  output logic              start_prog,
  output logic              start_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  logic [7:0] code;
  rmode_e     mode_d;
  seq_e       seq_d;
  logic       go_prog, go_erase;

  assign code = wr_data[7:0];

  always_comb begin
    mode_d   = mode_q;
    seq_d    = seq_q;
    clr_req  = 1'b0;
    seq_err  = 1'b0;
    go_prog  = 1'b0;
    go_erase = 1'b0;
    if (wr_en) begin
      case (seq_q)
        SEQ_PROG: begin
          go_prog = 1'b1;
          mode_d  = MODE_STATUS;
          seq_d   = SEQ_IDLE;
        end
        SEQ_ERASE: begin
          if (code == CMD_CONFIRM) go_erase = 1'b1;
          else                     seq_err  = 1'b1;
          mode_d = MODE_STATUS;
          seq_d  = SEQ_IDLE;
        end
        default: begin
          case (code)
            CMD_ARRAY:  mode_d = MODE_ARRAY;
            CMD_STATUS: mode_d = MODE_STATUS;
            CMD_IDENT:  mode_d = MODE_IDENT;
            CMD_QUERY:  mode_d = MODE_QUERY;
            CMD_CLEAR:  clr_req = 1'b1;
            CMD_PROG: begin
              mode_d = MODE_STATUS;
              seq_d  = SEQ_PROG;
            end
            CMD_ERASE: begin
              mode_d = MODE_STATUS;
              seq_d  = SEQ_ERASE;
            end
            default:    mode_d = MODE_STATUS;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_ARRAY;
      seq_q       <= SEQ_IDLE;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      mode_q      <= mode_d;
      seq_q       <= seq_d;
      start_prog  <= go_prog;
      start_erase <= go_erase;
      if (go_prog || go_erase) op_addr <= wr_addr;
      if (go_prog)             op_data <= wr_data;
    end
  end
endmodule

// File: rtl/fcd_status_reg.sv
module fcd_status_reg
  import fcd_pkg::*;
#(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  logic [SR_W-1:0] err_set,
  input  logic            seq_err,
  input  logic            clr_req,
  output logic [SR_W-1:0] status
);
  logic [SR_W-1:0] err_q, err_d;

  always_comb begin
    err_d = clr_req ? '0 : err_q;
    err_d = err_d | (err_set & SR_ERR_MASK);
    if (seq_err) err_d = err_d | SR_SEQ_ERR;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_d;
  end

  always_comb begin
    status           = err_q;
    status[SR_READY] = ~busy;
  end
endmodule

// File: rtl/fcd_read_port.sv
module fcd_read_port
  import fcd_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 16,
  parameter int              SR_W     = 8,
  parameter logic [DATA_W-1:0] MFR_ID   = 16'h0089,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h8817,
  parameter logic [DATA_W-1:0] CFG_WORD = 16'hBFCF
) (
  input  logic              clk,
  input  logic              rst,
  input  rmode_e            mode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic [SR_W-1:0]   status,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int ID_OFF_W = 4;
  localparam int Q_OFF_W  = 6;

  logic [DATA_W-1:0] id_word, sel;

  always_comb begin
    case (rd_addr[ID_OFF_W-1:0])
      4'd0:    id_word = MFR_ID;
      4'd1:    id_word = DEV_ID;
      4'd5:    id_word = CFG_WORD;
      default: id_word = '0;
    endcase
  end

  always_comb begin
    sel = '0;
    case (mode)
      MODE_ARRAY:  sel = arr_data;
      MODE_STATUS: sel[SR_W-1:0] = status;
      MODE_IDENT:  sel = id_word;
      default:     sel[7:0] = query_byte(rd_addr[Q_OFF_W-1:0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter int              DATA_W   = 16,
  parameter int              SR_W     = 8,
  parameter logic [DATA_W-1:0] MFR_ID   = 16'h0089,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h8817,
  parameter logic [DATA_W-1:0] CFG_WORD = 16'hBFCF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              wsm_busy,
  input  logic [SR_W-1:0]   wsm_err_set,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              start_prog,
  output logic              start_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  rmode_e          mode_q;
  seq_e            seq_q;
  logic            clr_req, seq_err;
  logic [SR_W-1:0] status;

  fcd_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .mode_q, .seq_q, .clr_req, .seq_err,
    .start_prog, .start_erase, .op_addr, .op_data
  );

  fcd_status_reg #(.SR_W(SR_W)) u_sr (
    .clk, .rst, .busy(wsm_busy), .err_set(wsm_err_set),
    .seq_err, .clr_req, .status
  );

  fcd_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SR_W(SR_W),
    .MFR_ID(MFR_ID), .DEV_ID(DEV_ID), .CFG_WORD(CFG_WORD)
  ) u_rd (
    .clk, .rst, .mode(mode_q), .rd_en, .rd_addr, .arr_data,
    .status, .rd_data, .rd_valid
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wsm_busy,
  input rmode_e            mode_q,
  input seq_e              seq_q,
  input logic [7:0]        status,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              start_prog,
  input logic              start_erase
);
  logic [7:0] c;
  logic       known;
  assign c = wr_data[7:0];
  assign known = (c == 8'hFF) || (c == 8'h70) || (c == 8'h90) || (c == 8'h98) ||
                 (c == 8'h50) || (c == 8'h40) || (c == 8'h20);

  a_r10_illegal_to_status: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_q == SEQ_IDLE && !known) |=> (mode_q == MODE_STATUS));

  a_r9_broken_erase_flags: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq_q == SEQ_ERASE && c != 8'hD0) |=> (status[5] && status[4] && !start_erase));

  a_r6_error_sticky: assert property (@(posedge clk) disable iff (rst)
    (status[3] && !(wr_en && seq_q == SEQ_IDLE && c == 8'h50)) |=> status[3]);

  a_r7_single_launch: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_prog, start_erase}));

  a_r3_status_read_shape: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(mode_q) == MODE_STATUS) |->
      (rd_data[15:8] == 8'h00 && rd_data[7] == !$past(wsm_busy)));

  a_r5_query_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(mode_q) == MODE_QUERY) |-> (rd_data[15:8] == 8'h00));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk, .rst, .wr_en, .wr_data, .wsm_busy, .mode_q, .seq_q, .status,
  .rd_data, .rd_valid, .start_prog, .start_erase
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0, wsm_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [7:0]    wsm_err_set = '0;
  logic [DW-1:0] arr_data, rd_data, op_data;
  logic [AW-1:0] op_addr;
  logic          rd_valid, start_prog, start_erase;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] arr_f(input logic [AW-1:0] a);
    return 16'h5A00 ^ {4'h0, a} ^ {a[3:0], 12'h000};
  endfunction
  assign arr_data = arr_f(rd_addr);

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_en, .rd_addr, .arr_data,
    .wsm_busy, .wsm_err_set, .rd_data, .rd_valid, .start_prog, .start_erase,
    .op_addr, .op_data
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [7:0] es = 8'h00);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wsm_err_set = es;
    @(negedge clk);
    wr_en = 1'b0; wsm_err_set = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected rd_valid", rd_data, 16'h0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rd_valid == 1'b0, "R1 rd_valid after reset", {15'h0, rd_valid}, 16'h0);
    check(start_prog == 1'b0 && start_erase == 1'b0, "R1 launches idle after reset",
          {14'h0, start_prog, start_erase}, 16'h0);
    rd(12'h003, arr_f(12'h003), "R1 array mode after reset");
    rd(12'h07F, arr_f(12'h07F), "R2 array read");
    wr(12'h000, 16'h0070);
    rd(12'h000, 16'h0000 | 16'h0080, "R1 R3 status clear after reset");
    check(rd_valid == 1'b1, "R11 rd_valid one cycle after rd_en", {15'h0, rd_valid}, 16'h1);
    @(negedge clk);
    check(rd_valid == 1'b0, "R11 rd_valid single pulse", {15'h0, rd_valid}, 16'h0);
    wsm_busy = 1'b1;
    rd(12'h000, 16'h0000, "R3 busy clears ready");
    wsm_busy = 1'b0;
    wr(12'h000, 16'hFF00 | 16'h00FF);
    rd(12'h0AA, arr_f(12'h0AA), "R2 back to array");
    // identifier
    wr(12'h000, 16'h0090);
    rd(12'h000, 16'h0089, "R4 mfr id");
    rd(12'h021, 16'h8817, "R4 dev id by low bits");
    rd(12'h005, 16'hBFCF, "R4 cfg word");
    rd(12'h003, 16'h0000, "R4 other offset zero");
    // query
    wr(12'h000, 16'h0098);
    rd(12'h010, 16'h0051, "R5 query Q");
    rd(12'h012, 16'h0059, "R5 query Y");
    rd(12'h027, 16'h0017, "R5 query size");
    rd(12'h005, 16'h0000, "R5 query unlisted");
    // error bits
    wr(12'h000, 16'h0070, 8'hFF);
    rd(12'h000, 16'h00BA, "R6 masked error set");
    rd(12'h000, 16'h00BA, "R6 error sticky");
    wr(12'h000, 16'h0050);
    rd(12'h000, 16'h0080, "R6 clear keeps status mode");
    wr(12'h000, 16'h0070, 8'h08);
    wr(12'h000, 16'h0050, 8'h02);
    rd(12'h000, 16'h0082, "R6 set wins over clear");
    wr(12'h000, 16'h0050);
    // illegal codes
    wr(12'h000, 16'h00FF);
    wr(12'h000, 16'h0000);
    rd(12'h001, 16'h0080, "R10 code 00 to status");
    wr(12'h000, 16'h00FF);
    wr(12'h000, 16'hFFD0);
    rd(12'h001, 16'h0080, "R10 lone confirm to status");
    wr(12'h000, 16'h00FF);
    wr(12'h000, 16'h0050);
    rd(12'h044, arr_f(12'h044), "R6 clear keeps array mode");
    // program
    wr(12'h000, 16'h0040);
    rd(12'h000, 16'h0080, "R7 program setup to status");
    wr(12'h123, 16'h00FF);
    check(start_prog == 1'b1, "R7 start_prog pulse", {15'h0, start_prog}, 16'h1);
    check(op_addr == 12'h123 && op_data == 16'h00FF, "R7 op address/data",
          op_data, 16'h00FF);
    check(start_erase == 1'b0, "R7 no erase on program", {15'h0, start_erase}, 16'h0);
    @(negedge clk);
    check(start_prog == 1'b0, "R7 start_prog one cycle", {15'h0, start_prog}, 16'h0);
    rd(12'h000, 16'h0080, "R7 data word not decoded");
    // erase
    wr(12'h000, 16'h00FF);
    wr(12'h400, 16'h0020);
    wr(12'h400, 16'h00D0);
    check(start_erase == 1'b1 && op_addr == 12'h400, "R8 erase launch",
          {4'h0, op_addr}, 16'h0400);
    rd(12'h000, 16'h0080, "R8 erase to status");
    // broken erase
    wr(12'h000, 16'h0020);
    wr(12'h000, 16'h00FF);
    check(start_erase == 1'b0, "R9 no erase launch", {15'h0, start_erase}, 16'h0);
    rd(12'h000, 16'h00B0, "R9 sequence error bits");
    wr(12'h000, 16'h0090);
    rd(12'h000, 16'h0089, "R9 sequence abandoned");
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    finish_run();
  end
endmodule